// File: doc/BRIEF.md
# Extended Error Register Dump Sequencer

This block collects a unit's extended error state once a failure has occurred. It acts as a master on a simple 64-bit register bus and produces a stream of capture records. Each record holds the register address, an index and the value that was read. The walk has two phases.

In the first phase the block reads a pointer register. The pointer leads to a list of descriptor words. Each descriptor names either one register to read several times or a run of consecutive registers. In the second phase the block visits a fixed set of diagnostic rings. For each ring it reads a map register. For every trace number it writes a selector value and then drains a mailbox register. Every address is formed as the unit base input ORed with an offset.

A size-only mode performs the same walk of the pointer, the descriptor list and the ring maps. In that mode it issues no selector writes, no data reads and no mailbox reads, and it reports only the number of records a full dump would produce. Records beyond the capture capacity are counted but not emitted, and they set a sticky overflow flag.

Top module: `err_dump_seq`

## Requirements
- R1: A one-cycle `start` while idle latches `unitBase` and `sizeOnly`, raises `busy` on the next cycle and reads the pointer at `unitBase | PTR_OFFS`; a pointer value of all zeros or all ones skips the descriptor phase.
- R2: Descriptor words are read from `unitBase | pointer[31:0]` at successive 8-byte addresses; a word of all zeros or all ones ends the list.
- R3: A descriptor with bit 39 set reads address `unitBase | word[23:0]` exactly `word[38:24]` times, and the records carry the indices 0, 1, 2 and so on.
- R4: A descriptor with bit 39 clear reads `word[38:24]/8` registers (the division truncates) at consecutive addresses 8 bytes apart, starting at `unitBase | word[23:0]`, each with index 0.
- R5: Rings 0 to RINGS-1 are visited in order. The map of ring r is read at `unitBase | (MAP_OFFS + 8*r)`. A map value of zero or all ones skips the ring. Otherwise the map gives the trap count in bits 31:24, the trace count in bits 23:16 and the entries per trace in bits 15:0.
- R6: For each trace t from 0 up to and including the trace count, the selector value `{ring[7:0], t[7:0]}` is written to `unitBase | SEL_OFFS` before any mailbox read of that trace. Trace 0 then reads the mailbox trap-count times, and every other trace reads it entries-per-trace times.
- R7: A mailbox record has address `unitBase | MBX_OFFS`, index `{selector[15:0], entry[15:0]}` and the value returned by the bus.
- R8: In size-only mode no selector write, data read, mailbox read or record takes place. `recCount` at `done` equals the sum of the repeat lengths, the range lengths divided by 8, and traps + traces × entries over the rings that are not skipped.
- R9: Only the first CAP records of a walk appear on `recValid`. Every further record still increments `recCount` and sets `overflow`, which holds until the next start.
- R10: A bus request stays asserted with a stable address until `busAck`, and only one access is outstanding at a time.
- R11: At the end of a walk `done` pulses for one cycle, `busy` then falls, and `recCount` equals the total number of records of the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk; ignored while busy |
| sizeOnly | input | 1 | Count records without reading data |
| unitBase | input | 32 | Base ORed into every bus address |
| busReq | output | 1 | Bus access request |
| busWe | output | 1 | Access is a write |
| busAddr | output | 32 | Bus byte address |
| busWdata | output | 64 | Write data |
| busAck | input | 1 | Access complete; read data valid |
| busRdata | input | 64 | Read data |
| recValid | output | 1 | Capture record valid for one cycle |
| recAddr | output | 32 | Record address |
| recIdx | output | 32 | Record index |
| recData | output | 64 | Record value |
| recCount | output | 32 | Records produced or counted in this walk |
| overflow | output | 1 | A record exceeded the capture capacity |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |

## Verification
Directed layouts set apart the two kinds of empty pointer, repeat descriptors from range descriptors (including a range shorter than 8 bytes and a zero-length repeat), a ring with no traps, and skipped rings with both empty codes. A walk that produces more records than the capture capacity shows that emission stops while counting continues, and the walk after it shows that the overflow flag clears. Seeded random layouts of lists and ring maps under varying unit bases are each run twice, once as a full dump and once in size-only mode. This checks that both modes agree on the record count and that the bus traffic of the size-only run stays free of selector writes.

// File: rtl/err_dump_pkg.sv
package err_dump_pkg;
  localparam int IW = 32;

  typedef enum logic [2:0] {
    S_IDLE, S_PTR, S_DESC, S_DATA, S_MAP, S_SEL, S_MBX, S_DONE
  } seqStateT;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_PTR, ACC_DESC, ACC_DATA, ACC_MAP, ACC_SEL, ACC_MBX
  } accKindT;

  typedef struct packed {
    accKindT acc;
    logic    clear;
    logic    ldList;
    logic    ldDesc;
    logic    cntDesc;
    logic    stepData;
    logic    cntMap;
    logic    ldMap;
    logic    nextRing;
    logic    ldSel;
    logic    stepMbx;
    logic    nextTrace;
  } ctlStrobeT;
endpackage

// File: rtl/err_dump_ctl.sv
module err_dump_ctl
  import err_dump_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      busAck,
  input  logic      rdEmpty,
  input  logic      dLeftZero,
  input  logic      entLeftZero,
  input  logic      lastTrace,
  input  logic      lastRing,
  input  logic      modeSize,
  output ctlStrobeT strb,
  output logic      busReq,
  output logic      busWe,
  output logic      busy,
  output logic      done
);
  seqStateT st, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    strb   = '0;
    nxt    = st;
    busReq = 1'b0;
    busWe  = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        strb.clear = 1'b1;
        nxt = S_PTR;
      end
      S_PTR: begin
        strb.acc = ACC_PTR;
        busReq = 1'b1;
        if (busAck) begin
          if (rdEmpty) nxt = S_MAP;
          else begin
            strb.ldList = 1'b1;
            nxt = S_DESC;
          end
        end
      end
      S_DESC: begin
        strb.acc = ACC_DESC;
        busReq = 1'b1;
        if (busAck) begin
          if (rdEmpty) nxt = S_MAP;
          else begin
            strb.ldDesc = 1'b1;
            if (modeSize) strb.cntDesc = 1'b1;
            else          nxt = S_DATA;
          end
        end
      end
      S_DATA: begin
        if (dLeftZero) nxt = S_DESC;
        else begin
          strb.acc = ACC_DATA;
          busReq = 1'b1;
          if (busAck) strb.stepData = 1'b1;
        end
      end
      S_MAP: begin
        strb.acc = ACC_MAP;
        busReq = 1'b1;
        if (busAck) begin
          if (rdEmpty || modeSize) begin
            strb.cntMap = !rdEmpty;
            if (lastRing) nxt = S_DONE;
            else strb.nextRing = 1'b1;
          end else begin
            strb.ldMap = 1'b1;
            nxt = S_SEL;
          end
        end
      end
      S_SEL: begin
        strb.acc = ACC_SEL;
        busReq = 1'b1;
        busWe = 1'b1;
        if (busAck) begin
          strb.ldSel = 1'b1;
          nxt = S_MBX;
        end
      end
      S_MBX: begin
        if (entLeftZero) begin
          if (!lastTrace) begin
            strb.nextTrace = 1'b1;
            nxt = S_SEL;
          end else if (lastRing) nxt = S_DONE;
          else begin
            strb.nextRing = 1'b1;
            nxt = S_MAP;
          end
        end else begin
          strb.acc = ACC_MBX;
          busReq = 1'b1;
          if (busAck) strb.stepMbx = 1'b1;
        end
      end
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign busy = (st != S_IDLE);
  assign done = (st == S_DONE);
endmodule

// File: rtl/err_dump_dp.sv
module err_dump_dp
  import err_dump_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int CW = 32,
  parameter int CAP = 1024,
  parameter int RINGS = 8,
  parameter logic [31:0] PTR_OFFS = 32'h0000_1000,
  parameter logic [31:0] MAP_OFFS = 32'h0000_1100,
  parameter logic [31:0] SEL_OFFS = 32'h0000_1200,
  parameter logic [31:0] MBX_OFFS = 32'h0000_1208
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobeT     strb,
  input  logic          sizeOnly,
  input  logic [AW-1:0] unitBase,
  input  logic [DW-1:0] busRdata,
  output logic [AW-1:0] busAddr,
  output logic [DW-1:0] busWdata,
  output logic          rdEmpty,
  output logic          dLeftZero,
  output logic          entLeftZero,
  output logic          lastTrace,
  output logic          lastRing,
  output logic          modeSize,
  output logic          recValid,
  output logic [AW-1:0] recAddr,
  output logic [IW-1:0] recIdx,
  output logic [DW-1:0] recData,
  output logic [CW-1:0] recCount,
  output logic          overflow
);
  localparam int RW = (RINGS > 1) ? $clog2(RINGS) : 1;
  localparam int LW = 15;

  logic [AW-1:0] baseQ, listAddr, dAddr;
  logic [LW-1:0] dLeft, dIdx;
  logic          dRep, modeQ;
  logic [RW-1:0] ring;
  logic [7:0]    trace, traps, traces;
  logic [15:0]   entries, entLeft, entNo;

  wire           descRep = busRdata[39];
  wire [LW-1:0]  descLen = busRdata[38:24];
  wire [LW-1:0]  descCnt = descRep ? descLen : (descLen >> 3);
  wire [15:0]    selVal  = {8'(ring), trace};
  wire [CW-1:0]  mapCnt  = CW'(busRdata[31:24]) +
                           CW'(busRdata[23:16]) * CW'(busRdata[15:0]);
  wire           roomLeft = recCount < CW'(CAP);
  wire           emit     = strb.stepData || strb.stepMbx;

  always_comb begin
    case (strb.acc)
      ACC_PTR:  busAddr = baseQ | AW'(PTR_OFFS);
      ACC_DESC: busAddr = listAddr;
      ACC_DATA: busAddr = dAddr;
      ACC_MAP:  busAddr = baseQ | (AW'(MAP_OFFS) + (AW'(ring) << 3));
      ACC_SEL:  busAddr = baseQ | AW'(SEL_OFFS);
      ACC_MBX:  busAddr = baseQ | AW'(MBX_OFFS);
      default:  busAddr = '0;
    endcase
    busWdata = (strb.acc == ACC_SEL) ? DW'(selVal) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0; modeQ <= 1'b0; listAddr <= '0; dAddr <= '0;
      dLeft <= '0; dIdx <= '0; dRep <= 1'b0; ring <= '0;
      trace <= '0; traps <= '0; traces <= '0; entries <= '0;
      entLeft <= '0; entNo <= '0; recCount <= '0; overflow <= 1'b0;
      recValid <= 1'b0; recAddr <= '0; recIdx <= '0; recData <= '0;
    end else begin
      recValid <= 1'b0;
      if (strb.clear) begin
        baseQ <= unitBase; modeQ <= sizeOnly;
        recCount <= '0; overflow <= 1'b0; ring <= '0;
      end
      if (strb.ldList) listAddr <= baseQ | busRdata[AW-1:0];
      if (strb.ldDesc) begin
        dAddr <= baseQ | AW'(busRdata[23:0]);
        dLeft <= descCnt; dIdx <= '0; dRep <= descRep;
        listAddr <= listAddr + AW'(8);
      end
      if (strb.cntDesc) recCount <= recCount + CW'(descCnt);
      if (strb.cntMap)  recCount <= recCount + mapCnt;
      if (strb.stepData) begin
        dLeft <= dLeft - 1'b1;
        if (dRep) dIdx <= dIdx + 1'b1;
        else      dAddr <= dAddr + AW'(8);
      end
      if (strb.ldMap) begin
        traps <= busRdata[31:24]; traces <= busRdata[23:16];
        entries <= busRdata[15:0]; trace <= '0;
      end
      if (strb.nextRing) ring <= ring + 1'b1;
      if (strb.nextTrace) trace <= trace + 1'b1;
      if (strb.ldSel) begin
        entLeft <= (trace == 8'd0) ? 16'(traps) : entries;
        entNo <= '0;
      end
      if (strb.stepMbx) begin
        entLeft <= entLeft - 1'b1;
        entNo <= entNo + 1'b1;
      end
      if (emit) begin
        recCount <= recCount + 1'b1;
        if (roomLeft) begin
          recValid <= 1'b1;
          recAddr  <= busAddr;
          recIdx   <= strb.stepMbx ? {selVal, entNo} : IW'(dIdx);
          recData  <= busRdata;
        end else begin
          overflow <= 1'b1;
        end
      end
    end
  end

  assign rdEmpty     = (busRdata == '0) || (&busRdata);
  assign dLeftZero   = (dLeft == '0);
  assign entLeftZero = (entLeft == '0);
  assign lastTrace   = (trace == traces);
  assign lastRing    = (ring == RW'(RINGS - 1));
  assign modeSize    = modeQ;
endmodule

// File: rtl/err_dump_seq.sv
module err_dump_seq
  import err_dump_pkg::*;
#(
  parameter int CW = 32,
  parameter int CAP = 1024,
  parameter int RINGS = 8,
  parameter logic [31:0] PTR_OFFS = 32'h0000_1000,
  parameter logic [31:0] MAP_OFFS = 32'h0000_1100,
  parameter logic [31:0] SEL_OFFS = 32'h0000_1200,
  parameter logic [31:0] MBX_OFFS = 32'h0000_1208
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          sizeOnly,
  input  logic [31:0]   unitBase,
  output logic          busReq,
  output logic          busWe,
  output logic [31:0]   busAddr,
  output logic [63:0]   busWdata,
  input  logic          busAck,
  input  logic [63:0]   busRdata,
  output logic          recValid,
  output logic [31:0]   recAddr,
  output logic [31:0]   recIdx,
  output logic [63:0]   recData,
  output logic [CW-1:0] recCount,
  output logic          overflow,
  output logic          busy,
  output logic          done
);
  ctlStrobeT strb;
  logic rdEmpty, dLeftZero, entLeftZero, lastTrace, lastRing, modeSize;

  err_dump_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .busAck(busAck),
    .rdEmpty(rdEmpty), .dLeftZero(dLeftZero), .entLeftZero(entLeftZero),
    .lastTrace(lastTrace), .lastRing(lastRing), .modeSize(modeSize),
    .strb(strb), .busReq(busReq), .busWe(busWe), .busy(busy), .done(done)
  );

  err_dump_dp #(
    .AW(32), .DW(64), .CW(CW), .CAP(CAP), .RINGS(RINGS),
    .PTR_OFFS(PTR_OFFS), .MAP_OFFS(MAP_OFFS),
    .SEL_OFFS(SEL_OFFS), .MBX_OFFS(MBX_OFFS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .sizeOnly(sizeOnly),
    .unitBase(unitBase), .busRdata(busRdata), .busAddr(busAddr),
    .busWdata(busWdata), .rdEmpty(rdEmpty), .dLeftZero(dLeftZero),
    .entLeftZero(entLeftZero), .lastTrace(lastTrace), .lastRing(lastRing),
    .modeSize(modeSize), .recValid(recValid), .recAddr(recAddr),
    .recIdx(recIdx), .recData(recData), .recCount(recCount),
    .overflow(overflow)
  );
endmodule

// File: rtl/err_dump_seq_chk.sv
module err_dump_seq_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        busReq,
  input logic        busAck,
  input logic [31:0] busAddr,
  input logic        recValid,
  input logic        overflow
);
  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R10
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr)));

  // R9
  rec_after_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(recValid && overflow));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !(start && !busy)) |=> overflow);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R11
  rec_in_walk_chk: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> busy);
endmodule

bind err_dump_seq err_dump_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .busReq(busReq), .busAck(busAck), .busAddr(busAddr),
  .recValid(recValid), .overflow(overflow)
);

// File: tb/err_dump_seq_bench.sv
module err_dump_seq_bench;
  localparam int CAP = 48;
  localparam logic [31:0] PTR_O = 32'h0000_1000;
  localparam logic [31:0] MAP_O = 32'h0000_1100;
  localparam logic [31:0] SEL_O = 32'h0000_1200;
  localparam logic [31:0] MBX_O = 32'h0000_1208;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, sizeOnly = 1'b0;
  logic [31:0] unitBase = '0;
  logic busReq, busWe, busAck, recValid, overflow, busy, done;
  logic [31:0] busAddr, recAddr, recIdx, recCount;
  logic [63:0] busWdata, busRdata, recData;

  always #10 clk = ~clk;

  err_dump_seq #(.CAP(CAP)) u_err_dump_seq (
    .clk(clk), .rstN(rstN), .start(start), .sizeOnly(sizeOnly),
    .unitBase(unitBase), .busReq(busReq), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busAck(busAck), .busRdata(busRdata),
    .recValid(recValid), .recAddr(recAddr), .recIdx(recIdx),
    .recData(recData), .recCount(recCount), .overflow(overflow),
    .busy(busy), .done(done)
  );

  logic [63:0]  memA [logic [31:0]];
  logic [127:0] expQ[$], gotQ[$];
  logic [95:0]  expWr[$], wrQ[$];
  int unsigned  expTotal;
  int unsigned  mbxCnt = 0;
  logic [15:0]  lastSel = '0;
  logic [31:0]  curBase = '0;
  int nChecks = 0, nFail = 0;

  function automatic logic [63:0] rdMem(input logic [31:0] a);
    return memA.exists(a) ? memA[a] : {a, ~a};
  endfunction
  function automatic bit isEmpty(input logic [63:0] w);
    return (w == 64'd0) || (&w);
  endfunction
  function automatic logic [63:0] mbxData(input logic [15:0] s, input int unsigned c);
    return {16'hB0B0, s, c};
  endfunction
  function automatic logic [63:0] descW(input bit rep, input int unsigned len, input logic [23:0] a);
    return {24'd0, rep, len[14:0], a};
  endfunction
  function automatic logic [63:0] mapW(input int unsigned tp, input int unsigned tc, input int unsigned en);
    return {32'd0, tp[7:0], tc[7:0], en[15:0]};
  endfunction

  // bus responder: one access at a time, ack one cycle after the request
  always @(posedge clk) begin
    if (!rstN) busAck <= 1'b0;
    else begin
      busAck <= busReq && !busAck;
      if (busReq && !busAck) begin
        if (busWe) begin
          wrQ.push_back({busAddr, busWdata});
          if (busAddr == (curBase | SEL_O)) lastSel <= busWdata[15:0];
        end else if (busAddr == (curBase | MBX_O)) begin
          busRdata <= mbxData(lastSel, mbxCnt);
          mbxCnt <= mbxCnt + 1;
        end else busRdata <= rdMem(busAddr);
      end
    end
  end

  always @(negedge clk) if (recValid) gotQ.push_back({recAddr, recIdx, recData});

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic addRec(input bit sz, input logic [31:0] a, input logic [31:0] i,
                        input logic [63:0] d);
    expTotal++;
    if (!sz) expQ.push_back({a, i, d});
  endtask

  // reference walk computed from the requirements
  task automatic buildExp(input logic [31:0] b, input bit sz);
    logic [63:0] w, e;
    logic [31:0] la, da;
    logic [15:0] sel;
    int unsigned len, n, mc;
    expQ.delete(); expWr.delete(); expTotal = 0; mc = mbxCnt;
    w = rdMem(b | PTR_O);
    if (!isEmpty(w)) begin                                   // R1
      la = b | w[31:0];
      for (int g = 0; g < 64; g++) begin                     // R2
        e = rdMem(la);
        if (isEmpty(e)) break;
        da = b | {8'd0, e[23:0]};
        len = e[38:24];
        if (e[39]) for (int i = 0; i < len; i++) addRec(sz, da, i, rdMem(da));   // R3
        else for (int i = 0; i < (len >> 3); i++)                                  // R4
          addRec(sz, da + 8 * i, 0, rdMem(da + 8 * i));
        la += 8;
      end
    end
    for (int r = 0; r < 8; r++) begin                        // R5
      w = rdMem(b | (MAP_O + 8 * r));
      if (isEmpty(w)) continue;
      for (int t = 0; t <= int'(w[23:16]); t++) begin        // R6
        sel = {r[7:0], t[7:0]};
        if (!sz) expWr.push_back({b | SEL_O, 48'd0, sel});
        n = (t == 0) ? w[31:24] : w[15:0];
        for (int k = 0; k < n; k++) begin                    // R7
          addRec(sz, b | MBX_O, {sel, k[15:0]}, mbxData(sel, mc));
          if (!sz) mc++;
        end
      end
    end
  endtask

  task automatic runWalk(input logic [31:0] b, input bit sz, input string tag);
    int unsigned nExp, waited;
    buildExp(b, sz);
    gotQ.delete(); wrQ.delete();
    curBase = b;
    @(negedge clk); start = 1'b1; sizeOnly = sz; unitBase = b;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R1", {tag, " busy after start"}, 128'(busy), 128'(1));
    waited = 0;
    while (!done && waited < 20000) begin @(negedge clk); waited++; end
    check(done == 1'b1, "R11", {tag, " walk finished"}, 128'(done), 128'(1));
    check(recCount == expTotal, sz ? "R8" : "R11", {tag, " record count"},
          128'(recCount), 128'(expTotal));
    check(overflow == (expTotal > CAP), "R9", {tag, " overflow flag"},
          128'(overflow), 128'(expTotal > CAP));
    nExp = sz ? 0 : ((expTotal > CAP) ? CAP : expTotal);
    check(gotQ.size() == nExp, sz ? "R8" : "R9", {tag, " records emitted"},
          128'(gotQ.size()), 128'(nExp));
    for (int i = 0; i < gotQ.size() && i < nExp; i++)
      check(gotQ[i] == expQ[i], "R7", {tag, " record content (R3/R4 for lists)"},
            gotQ[i], expQ[i]);
    check(wrQ.size() == expWr.size(), sz ? "R8" : "R6", {tag, " selector write count"},
          128'(wrQ.size()), 128'(expWr.size()));
    for (int i = 0; i < wrQ.size() && i < expWr.size(); i++)
      check(wrQ[i] == expWr[i], "R6", {tag, " selector write"},
            128'(wrQ[i]), 128'(expWr[i]));
    @(negedge clk);
    check(!busy && !done, "R11", {tag, " idle after done"}, 128'({busy, done}), 128'(0));
  endtask

  task automatic clearRings(input logic [31:0] b);
    memA.delete();
    for (int r = 0; r < 8; r++) memA[b | (MAP_O + 8 * r)] = 64'd0;
  endtask

  task automatic randomLayout(input logic [31:0] b);
    int unsigned nd, la;
    clearRings(b);
    if ($urandom_range(0, 3) == 0)
      memA[b | PTR_O] = $urandom_range(0, 1) ? 64'd0 : '1;
    else begin
      la = 32'h2000 + 8 * $urandom_range(0, 16);
      memA[b | PTR_O] = 64'(la);
      nd = $urandom_range(0, 3);
      for (int d = 0; d < nd; d++) begin
        if ($urandom_range(0, 1) != 0)
          memA[b | (la + 8 * d)] = descW(1, $urandom_range(0, 5), 24'h4000 + 24'(8 * $urandom_range(0, 64)));
        else
          memA[b | (la + 8 * d)] = descW(0, $urandom_range(0, 40), 24'h6000 + 24'(8 * $urandom_range(0, 64)));
      end
      memA[b | (la + 8 * nd)] = $urandom_range(0, 1) ? 64'd0 : '1;
    end
    for (int r = 0; r < 8; r++) begin
      case ($urandom_range(0, 3))
        0: memA[b | (MAP_O + 8 * r)] = '1;
        1: memA[b | (MAP_O + 8 * r)] = 64'd0;
        default: memA[b | (MAP_O + 8 * r)] =
          mapW($urandom_range(0, 3), $urandom_range(0, 2), $urandom_range(0, 3));
      endcase
    end
  endtask

  initial begin
    #(200000 * 20);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !recValid && !overflow && !done && !busReq && recCount == 0,
          "R11", "reset state", 128'({busy, recValid, overflow, done, busReq, recCount}), 128'(0));

    // R1 R5 R6 R7: empty pointer, one ring with traps and traces, one ring all ones
    clearRings(32'h0);
    memA[PTR_O] = 64'd0;
    memA[MAP_O + 8 * 2] = mapW(2, 2, 3);
    memA[MAP_O + 8 * 5] = '1;
    runWalk(32'h0, 1'b0, "zero pointer");

    // R1: all-ones pointer, nothing to dump
    clearRings(32'h0500_0000);
    memA[32'h0500_0000 | PTR_O] = '1;
    runWalk(32'h0500_0000, 1'b0, "ones pointer");

    // R2 R3 R4: repeat, range, short range, zero repeat, all-ones terminator; ring 7 with no traps
    clearRings(32'h0300_0000);
    memA[32'h0300_0000 | PTR_O] = 64'h2000;
    memA[32'h0300_2000] = descW(1, 3, 24'h4000);
    memA[32'h0300_2008] = descW(0, 20, 24'h5000);
    memA[32'h0300_2010] = descW(0, 5, 24'h5800);
    memA[32'h0300_2018] = descW(1, 0, 24'h4800);
    memA[32'h0300_2020] = '1;
    memA[32'h0300_0000 | (MAP_O + 8 * 7)] = mapW(0, 1, 2);
    runWalk(32'h0300_0000, 1'b0, "descriptor mix");
    // R8: same layout, size-only
    runWalk(32'h0300_0000, 1'b1, "descriptor mix size-only");

    // R9: overflow past capacity, then cleared by the next walk
    clearRings(32'h0);
    memA[PTR_O] = 64'h2000;
    memA[32'h2000] = descW(1, 60, 24'h4000);
    memA[32'h2008] = 64'd0;
    memA[MAP_O] = mapW(1, 1, 1);
    runWalk(32'h0, 1'b0, "overflow");
    clearRings(32'h0);
    memA[PTR_O] = 64'd0;
    memA[MAP_O + 8 * 2] = mapW(2, 2, 3);
    runWalk(32'h0, 1'b0, "overflow cleared");

    // random layouts, full dump and size-only on each
    for (int s = 0; s < 8; s++) begin
      logic [31:0] b;
      b = {4'd0, 4'($urandom_range(0, 15)), 24'd0};
      randomLayout(b);
      runWalk(b, 1'b0, "random full");
      runWalk(b, 1'b1, "random size-only");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule